// File: doc/BRIEF.md
# Concatenate-Increment Carry Skip Adder

This block adds two unsigned operands and a carry-in, and presents the sum and the carry-out one clock after the operands are applied. The operand width is split into consecutive stages. Stage 0 is a plain ripple chain that takes the external carry-in directly. Every later stage ripples its own operand slice with a carry-in of zero. An incrementer then adds the carry that actually arrives at that stage.

A skip cell in each stage after the first forms the carry that goes to the next stage. It combines the stage's zero-carry ripple carry-out, the AND of the stage's propagate bits and the incoming carry. The skip cells are inverting, and they alternate between an AND-OR-invert form and an OR-AND-invert form. As a result, the carry on a stage link is stored complemented after every odd-indexed stage and true after every other stage. Each consumer decodes the link with the polarity it expects.

Stage sizes come from a packed list parameter. A uniform list gives fixed-size stages. A non-uniform list, for example one that grows and then shrinks along the word, gives variable-size stages.

Top module: `cska_top`

## Requirements
- R1: One clock after a cycle in which reset is low, the concatenation {cout, sum} equals the (WIDTH+1)-bit value a + b + cin sampled in that cycle.
- R2: When rst is high at a rising clock edge, sum and cout are both 0 after that edge, whatever the operands are.
- R3: The true carry into stage j (j from 1 to NSTG, where stage NSTG means the carry-out of the word) equals the carry out of bit OFF(j)-1 of a + b + cin. OFF(j) is the sum of the sizes of stages 0 to j-1.
- R4: The link carry leaving stage k is stored complemented when k is odd and true when k is even. Stage 0 leaves a true carry. The final cout is always true for both an odd and an even stage count.
- R5: When a XOR b is all ones, the carry passes through every stage: cout equals cin, and sum is all ones for cin = 0 and all zeros for cin = 1.
- R6: Stage k occupies SIZES[8k+7:8k] bits, with stage 0 at the least significant bits. Any list whose sizes are each at least 1 and add up to WIDTH gives the same arithmetic result as any other such list.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Registered sum |
| cout | output | 1 | Registered carry out of the top bit |

## Verification
In any one cycle, the incrementer correction of a stage and the skip path of the same stage can both be active. This happens when the incoming carry is 1 and the stage's propagate product is 1, so the partial sum is all ones and the incrementer has to wrap it while the skip cell also forwards the carry. An exhaustive sweep of every 8-bit operand pair and carry-in, on both a uniform and a non-uniform stage list, provokes this case in every stage. Operands with a XOR b all ones provoke it in all stages at once. Each output is judged against the arithmetic sum computed in the bench. 32-bit configurations with odd and even stage counts run random and all-propagate vectors, so that both final link polarities are covered.

// File: rtl/cska_pkg.sv
package cska_pkg;
  localparam int unsigned MAX_STG = 32;

  // Width of stage k, taken from an 8-bit-per-entry packed list
  function automatic int stage_size(input logic [8*MAX_STG-1:0] sizes, input int k);
    return int'(sizes[8*k +: 8]);
  endfunction

  // Bit position where stage k starts
  function automatic int stage_off(input logic [8*MAX_STG-1:0] sizes, input int k);
    int o;
    o = 0;
    for (int i = 0; i < k; i++) o += stage_size(sizes, i);
    return o;
  endfunction
endpackage

// File: rtl/cska_ripple.sv
module cska_ripple #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co,
  output logic         pp
);
  logic [W:0]   c;
  logic [W-1:0] p;

  assign c[0] = ci;
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign p[i]   = a[i] ^ b[i];
    assign s[i]   = p[i] ^ c[i];
    assign c[i+1] = (a[i] & b[i]) | (p[i] & c[i]);
  end
  assign co = c[W];
  assign pp = &p;
endmodule

// File: rtl/cska_incr.sv
module cska_incr #(
  parameter int W = 4
) (
  input  logic [W-1:0] ps,
  input  logic         ci,
  output logic [W-1:0] s
);
  logic [W:0] t;

  assign t[0] = ci;
  for (genvar i = 0; i < W; i++) begin : g_inc
    assign t[i+1] = t[i] & ps[i];
    assign s[i]   = ps[i] ^ t[i];
  end
endmodule

// File: rtl/cska_skip.sv
module cska_skip #(
  parameter bit OAI_FORM = 1'b0
) (
  input  logic g,
  input  logic pp,
  input  logic link_in,
  output logic link_out
);
  if (OAI_FORM) begin : g_oai
    // link_in arrives complemented, link_out leaves true
    assign link_out = ~((~g) & ((~pp) | link_in));
  end else begin : g_aoi
    // link_in arrives true, link_out leaves complemented
    assign link_out = ~(g | (pp & link_in));
  end
endmodule

// File: rtl/cska_top.sv
module cska_top #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned NSTG  = 8,
  parameter logic [8*NSTG-1:0] SIZES = {8{8'd4}}
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  import cska_pkg::*;

  localparam logic [8*MAX_STG-1:0] SZ = (8*MAX_STG)'(SIZES);
  localparam bit LAST_NEG = (NSTG >= 2) && (NSTG % 2 == 0);

  logic [NSTG:0]    link;
  logic [WIDTH-1:0] sum_c;
  logic             cout_c;

  assign link[0] = cin;

  for (genvar k = 0; k < NSTG; k++) begin : g_stg
    localparam int W = stage_size(SZ, k);
    localparam int O = stage_off(SZ, k);

    if (k == 0) begin : g_head
      logic co, pp;
      cska_ripple #(.W(W)) u_rip (
        .a(a[O +: W]), .b(b[O +: W]), .ci(link[0]),
        .s(sum_c[O +: W]), .co(co), .pp(pp));
      assign link[1] = co;
    end else begin : g_body
      logic [W-1:0] ps;
      logic         co, pp, c_true;
      cska_ripple #(.W(W)) u_rip (
        .a(a[O +: W]), .b(b[O +: W]), .ci(1'b0),
        .s(ps), .co(co), .pp(pp));
      // even-indexed stages receive a complemented link
      assign c_true = (k % 2 == 0) ? ~link[k] : link[k];
      cska_incr #(.W(W)) u_inc (.ps(ps), .ci(c_true), .s(sum_c[O +: W]));
      cska_skip #(.OAI_FORM(k % 2 == 0)) u_skip (
        .g(co), .pp(pp), .link_in(link[k]), .link_out(link[k+1]));
    end
  end

  assign cout_c = LAST_NEG ? ~link[NSTG] : link[NSTG];

  always_ff @(posedge clk) begin
    if (rst) begin
      sum  <= '0;
      cout <= 1'b0;
    end else begin
      sum  <= sum_c;
      cout <= cout_c;
    end
  end
endmodule

// File: rtl/cska_chk.sv
module cska_chk #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned NSTG  = 8,
  parameter logic [8*NSTG-1:0] SIZES = {8{8'd4}}
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic             cin,
  input logic [WIDTH-1:0] sum,
  input logic             cout,
  input logic [NSTG:0]    link
);
  import cska_pkg::*;

  localparam logic [8*MAX_STG-1:0] SZ = (8*MAX_STG)'(SIZES);

  // R1: registered result is the arithmetic sum of the previous operands
  a_r1_sum: assert property (@(posedge clk) disable iff (rst)
    !rst |=> {cout, sum} == ({1'b0, $past(a)} + {1'b0, $past(b)} + (WIDTH+1)'($past(cin))));

  // R2: reset clears both outputs
  a_r2_reset_clear: assert property (@(posedge clk)
    rst |=> (sum == '0) && !cout);

  // R5: full propagate passes cin straight to cout
  a_r5_full_skip: assert property (@(posedge clk) disable iff (rst)
    (!rst && ((a ^ b) == {WIDTH{1'b1}})) |=> (cout == $past(cin)) && (sum == {WIDTH{~$past(cin)}}));

  for (genvar j = 1; j <= NSTG; j++) begin : g_link
    localparam int P = stage_off(SZ, j);
    localparam bit NEG = (j >= 2) && (j % 2 == 0);
    logic tc;
    assign tc = 1'(({1'b0, a[P-1:0]} + {1'b0, b[P-1:0]} + (P+1)'(cin)) >> P);

    // R3: decoded link carry matches the arithmetic carry at the boundary
    a_r3_link_carry: assert property (@(posedge clk) disable iff (rst)
      ((NEG ? ~link[j] : link[j]) == tc));

    // R4: raw link level carries the expected polarity
    a_r4_link_polarity: assert property (@(posedge clk) disable iff (rst)
      (link[j] == (tc ^ NEG)));
  end
endmodule

bind cska_top cska_chk #(.WIDTH(WIDTH), .NSTG(NSTG), .SIZES(SIZES)) u_cska_chk (
  .clk(clk), .rst(rst), .a(a), .b(b), .cin(cin),
  .sum(sum), .cout(cout), .link(link));

// File: tb/test_cska_top.sv
module test_cska_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [7:0]  a8 = 8'hff, b8 = 8'h01;
  logic [31:0] a32 = 32'hffff_ffff, b32 = 32'h1;
  logic        ci = 1'b1;
  logic [7:0]  sf8, sv8;
  logic [31:0] sf32, sv32;
  logic        cf8, cv8, cf32, cv32;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  // R6: uniform 4+4 and non-uniform 1,2,3,2 lists
  cska_top #(.WIDTH(8), .NSTG(2), .SIZES({8'd4, 8'd4})) i_cska_top_f8 (
    .clk(clk), .rst(rst), .a(a8), .b(b8), .cin(ci), .sum(sf8), .cout(cf8));
  cska_top #(.WIDTH(8), .NSTG(4), .SIZES({8'd2, 8'd3, 8'd2, 8'd1})) i_cska_top_v8 (
    .clk(clk), .rst(rst), .a(a8), .b(b8), .cin(ci), .sum(sv8), .cout(cv8));
  // R4: eight stages (last index odd) and seven stages (last index even)
  cska_top #(.WIDTH(32), .NSTG(8), .SIZES({8{8'd4}})) i_cska_top_f32 (
    .clk(clk), .rst(rst), .a(a32), .b(b32), .cin(ci), .sum(sf32), .cout(cf32));
  cska_top #(.WIDTH(32), .NSTG(7),
             .SIZES({8'd4, 8'd5, 8'd6, 8'd7, 8'd5, 8'd3, 8'd2})) i_cska_top (
    .clk(clk), .rst(rst), .a(a32), .b(b32), .cin(ci), .sum(sv32), .cout(cv32));

  task automatic chk(input string req, input logic [32:0] act, input logic [32:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog act=running exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [32:0] e;
    // R2: reset holds outputs at zero with nonzero operands
    repeat (2) @(negedge clk);
    chk("R2 f8", {24'd0, cf8, sf8}, 33'd0);
    chk("R2 v8", {24'd0, cv8, sv8}, 33'd0);
    chk("R2 f32", {cf32, sf32}, 33'd0);
    chk("R2 v32", {cv32, sv32}, 33'd0);
    rst = 1'b0;

    // R1 R3 R5 R6: exhaustive 8-bit sweep on both stage lists
    for (int x = 0; x < 131072; x++) begin
      a8 = x[7:0];
      b8 = x[15:8];
      ci = x[16];
      @(negedge clk);
      e = 33'({1'b0, a8} + {1'b0, b8} + 9'(ci));
      chk("R1 f8", {24'd0, cf8, sf8}, e);
      chk("R6 v8", {24'd0, cv8, sv8}, e);
      if ((a8 ^ b8) == 8'hff) begin
        chk("R5 f8", {24'd0, cf8, sf8}, {24'd0, ci, {8{~ci}}});
        chk("R5 v8", {24'd0, cv8, sv8}, {24'd0, ci, {8{~ci}}});
      end
    end

    // R1 R4: random 32-bit vectors, both final link polarities
    for (int n = 0; n < 3000; n++) begin
      a32 = $urandom;
      b32 = $urandom;
      ci  = 1'($urandom);
      @(negedge clk);
      e = {1'b0, a32} + {1'b0, b32} + 33'(ci);
      chk("R1 f32", {cf32, sf32}, e);
      chk("R4 v32", {cv32, sv32}, e);
    end

    // R5: all-propagate operands, carry skips every stage
    for (int n = 0; n < 200; n++) begin
      a32 = $urandom;
      b32 = ~a32;
      ci  = n[0];
      @(negedge clk);
      chk("R5 f32", {cf32, sf32}, {ci, {32{~ci}}});
      chk("R5 v32", {cv32, sv32}, {ci, {32{~ci}}});
    end

    // R3: carry generated at bit 0, rippling into all later stages
    a32 = 32'h0000_0001; b32 = 32'hffff_ffff; ci = 1'b0;
    @(negedge clk);
    chk("R3 f32", {cf32, sf32}, 33'h1_0000_0000);
    chk("R3 v32", {cv32, sv32}, 33'h1_0000_0000);

    // R2: reset in mid-run
    a32 = 32'h8000_0000; b32 = 32'h8000_0000; ci = 1'b1; a8 = 8'hff; b8 = 8'hff;
    rst = 1'b1;
    @(negedge clk);
    chk("R2 mid f32", {cf32, sf32}, 33'd0);
    chk("R2 mid v8", {24'd0, cv8, sv8}, 33'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset v32", {cv32, sv32}, 33'h1_0000_0001);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule